// File: doc/BRIEF.md
# Packet Header Protocol Interpreter

This block sits in one receive channel of a point-to-point serial link controller. It watches the decoded token stream: data bytes, plus a flag that marks an end-of-packet control token. In protocol mode it treats the first four data bytes of every packet as a header. The header fields are a destination address, a control byte, a transaction identifier and one spare byte. When the header is complete, the block makes one decision. It either opens the payload path into the receive FIFO, or it runs a simple control command, or it raises an error flag.

The command executor drives an active-low CPU reset, four active-low side-band signals and one reset pulse per link channel. Commands that could harm the system are gated by a one-shot arm latch. One command sets the latch, and it clears itself after one gated command has run. In transparent and routing modes the interpreter is bypassed: every data byte goes straight to the FIFO output.

A packet starts after reset, after the block enters protocol mode, or after any end-of-packet token. Command effects and error flags appear in the clock cycle after the fourth header byte is accepted.

Top module: `pkt_hdr_interp`

## Requirements
- R1: When `mode_i` is 0 (transparent) or 1 (routing), or 3, every data token appears on `fwd_valid_o`/`fwd_data_o` one cycle later. End-of-packet tokens are never forwarded. No header is interpreted and no command or error results.
- R2: When `mode_i` is 2 (protocol), the first four data tokens of a packet are header bytes, in this order: destination, control, transaction ID, spare. Header bytes are never forwarded.
- R3: Payload is forwarded one cycle after each token, and only when the destination equals `chan_addr_i` and the control opcode (bits 7:4) is 0x0. The payload of any other packet is dropped.
- R4: A destination that differs from `chan_addr_i` sets error bit 0 (address) and causes no command effect. The address check takes precedence over every other check.
- R5: Opcode 0x1 sets the arm latch. The gated opcodes are 0x2, 0x6 and 0x7. A gated opcode runs only while the latch is set, and running it clears the latch. A gated opcode received while the latch is clear sets error bit 2 and has no effect.
- R6: Opcode 0x2 drives `cpu_rst_n_o` low. Opcode 0x3, which is not gated, drives it high. Its reset value is high.
- R7: Opcode 0x4 drives low the bits of `sig_n_o` selected by control bits 3:0. Opcode 0x5 releases the selected bits, and neither opcode is gated. All bits are high after reset.
- R8: Opcode 0x6 pulses `link_rst_o[ctrl[1:0]]` for exactly one cycle, and opcode 0x7 pulses all bits of `link_rst_o`. Opcodes 0x8 to 0xF, and opcode 0x6 with an index of NLINK or more, set error bit 1 (unknown command).
- R9: `hdr_ctrl_o` and `hdr_tid_o` hold the control byte and the transaction ID of the most recently captured header. Both are zero after reset.
- R10: An end-of-packet token that arrives after 1 to 3 header bytes sets error bit 3 (short header). Parsing then restarts with a new header.
- R11: The bits of `err_flags_o` stay set until a 1 is written on the same bit of `err_clr_i`. A new error set in the same cycle as a clear wins. `irq_o` is the OR of `err_flags_o & irq_en_i`.
- R12: When `auto_ack_i` is high in protocol mode, each header byte appears on `ack_valid_o`/`ack_data_o` one cycle after its token. When `auto_ack_i` is low, nothing appears there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 transparent, 1 routing, 2 protocol |
| chan_addr_i | input | 8 | Channel address for the destination compare |
| auto_ack_i | input | 1 | Copy header bytes to the acknowledge queue |
| tok_valid_i | input | 1 | Token present this cycle |
| tok_eop_i | input | 1 | Token is an end-of-packet control token |
| tok_data_i | input | 8 | Data byte of the token |
| fwd_valid_o | output | 1 | Byte for the receive FIFO |
| fwd_data_o | output | 8 | Forwarded byte |
| ack_valid_o | output | 1 | Header byte for the acknowledge queue |
| ack_data_o | output | 8 | Header byte copy |
| hdr_ctrl_o | output | 8 | Last captured control byte |
| hdr_tid_o | output | 8 | Last captured transaction ID |
| cpu_rst_n_o | output | 1 | Active-low CPU reset |
| sig_n_o | output | NSIG | Active-low side-band signals |
| link_rst_o | output | NLINK | One-cycle link reset pulses |
| err_clr_i | input | 4 | Write-1-to-clear for the error flags |
| irq_en_i | input | 4 | Interrupt enable for each error flag |
| err_flags_o | output | 4 | Sticky flags: 0 address, 1 command, 2 disarmed, 3 short |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that bypass modes forward each data token, that header bytes and end-of-packet tokens never reach the FIFO output, and that a disarmed gated command changes nothing. They also check that a link reset pulse lasts one cycle, that a gated command leaves the latch clear, and that error flags fall only when cleared. Only the directed scenarios can show the full decision for each packet: which payload bytes arrive and with what values, the exact levels left on the CPU reset and side-band outputs, the one-shot arming sequence across several packets, the restart after a short header, and the bytes copied to the acknowledge queue.

// File: rtl/phi_pkg.sv
package phi_pkg;

  localparam logic [1:0] MODE_PROTO = 2'd2;

  localparam logic [3:0] OP_DATA     = 4'h0;
  localparam logic [3:0] OP_ARM      = 4'h1;
  localparam logic [3:0] OP_CPU_HOLD = 4'h2;
  localparam logic [3:0] OP_CPU_FREE = 4'h3;
  localparam logic [3:0] OP_SIG_SET  = 4'h4;
  localparam logic [3:0] OP_SIG_CLR  = 4'h5;
  localparam logic [3:0] OP_LINK_ONE = 4'h6;
  localparam logic [3:0] OP_LINK_ALL = 4'h7;

  localparam int ERR_W     = 4;
  localparam int ERR_ADDR  = 0;
  localparam int ERR_CMD   = 1;
  localparam int ERR_LOCK  = 2;
  localparam int ERR_SHORT = 3;

  typedef enum logic [2:0] {
    CL_DATA, CL_ARM, CL_GATED, CL_PLAIN, CL_BAD
  } cls_e;

  function automatic cls_e classify(input logic [7:0] ctl, input int nlink);
    case (ctl[7:4])
      OP_DATA:     return CL_DATA;
      OP_ARM:      return CL_ARM;
      OP_CPU_HOLD: return CL_GATED;
      OP_CPU_FREE: return CL_PLAIN;
      OP_SIG_SET:  return CL_PLAIN;
      OP_SIG_CLR:  return CL_PLAIN;
      OP_LINK_ONE: return (int'(ctl[1:0]) < nlink) ? CL_GATED : CL_BAD;
      OP_LINK_ALL: return CL_GATED;
      default:     return CL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/phi_hdr_track.sv
module phi_hdr_track #(
  parameter int HDR_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proto_i,
  input  logic       tok_valid_i,
  input  logic       tok_eop_i,
  input  logic [7:0] tok_data_i,
  output logic       hdr_stb_o,
  output logic       hdr_done_o,
  output logic       short_o,
  output logic       pay_stb_o,
  output logic       eop_o,
  output logic [7:0] dest_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] tid_o
);
  localparam int CW = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(HDR_LEN - 1);

  logic          in_pay;
  logic [CW-1:0] cnt;
  logic          data_tok;

  assign data_tok   = tok_valid_i & ~tok_eop_i;
  assign eop_o      = tok_valid_i & tok_eop_i;
  assign hdr_stb_o  = proto_i & ~in_pay & data_tok;
  assign hdr_done_o = hdr_stb_o & (cnt == LAST);
  assign short_o    = proto_i & eop_o & ~in_pay & (cnt != '0);
  assign pay_stb_o  = proto_i & in_pay & data_tok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pay <= 1'b0;
      cnt    <= '0;
      dest_o <= '0;
      ctrl_o <= '0;
      tid_o  <= '0;
    end else if (!proto_i || eop_o) begin
      in_pay <= 1'b0;
      cnt    <= '0;
    end else if (hdr_stb_o) begin
      case (cnt)
        CW'(0): dest_o <= tok_data_i;
        CW'(1): ctrl_o <= tok_data_i;
        CW'(2): tid_o  <= tok_data_i;
        default: ;
      endcase
      if (cnt == LAST) in_pay <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phi_cmd_exec.sv
module phi_cmd_exec
  import phi_pkg::*;
#(
  parameter int NLINK = 3,
  parameter int NSIG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [7:0]       ctl_i,
  output logic             armed_o,
  output logic             cpu_rst_n_o,
  output logic [NSIG-1:0]  sig_n_o,
  output logic [NLINK-1:0] link_rst_o
);
  logic [3:0]       op;
  logic [NSIG-1:0]  mask;
  logic [NLINK-1:0] link_hit;

  assign op   = ctl_i[7:4];
  assign mask = ctl_i[NSIG-1:0];

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    assign link_hit[g] = (op == OP_LINK_ALL) ||
                         ((op == OP_LINK_ONE) && (int'(ctl_i[1:0]) == g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o     <= 1'b0;
      cpu_rst_n_o <= 1'b1;
      sig_n_o     <= '1;
      link_rst_o  <= '0;
    end else begin
      link_rst_o <= '0;
      if (go_i) begin
        case (op)
          OP_ARM:      armed_o <= 1'b1;
          OP_CPU_HOLD: begin cpu_rst_n_o <= 1'b0; armed_o <= 1'b0; end
          OP_CPU_FREE: cpu_rst_n_o <= 1'b1;
          OP_SIG_SET:  sig_n_o <= sig_n_o & ~mask;
          OP_SIG_CLR:  sig_n_o <= sig_n_o | mask;
          OP_LINK_ONE,
          OP_LINK_ALL: begin link_rst_o <= link_hit; armed_o <= 1'b0; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/phi_err_bank.sv
module phi_err_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  for (genvar b = 0; b < W; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flags_o[b] <= 1'b0;
      else if (set_i[b]) flags_o[b] <= 1'b1;
      else if (clr_i[b]) flags_o[b] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/pkt_hdr_interp.sv
module pkt_hdr_interp
  import phi_pkg::*;
#(
  parameter int NLINK   = 3,
  parameter int NSIG    = 4,
  parameter int HDR_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [7:0]       chan_addr_i,
  input  logic             auto_ack_i,
  input  logic             tok_valid_i,
  input  logic             tok_eop_i,
  input  logic [7:0]       tok_data_i,
  output logic             fwd_valid_o,
  output logic [7:0]       fwd_data_o,
  output logic             ack_valid_o,
  output logic [7:0]       ack_data_o,
  output logic [7:0]       hdr_ctrl_o,
  output logic [7:0]       hdr_tid_o,
  output logic             cpu_rst_n_o,
  output logic [NSIG-1:0]  sig_n_o,
  output logic [NLINK-1:0] link_rst_o,
  input  logic [3:0]       err_clr_i,
  input  logic [3:0]       irq_en_i,
  output logic [3:0]       err_flags_o,
  output logic             irq_o
);
  logic       proto;
  logic       data_tok;
  logic       hdr_stb, hdr_done, hdr_short, pay_stb, eop_seen;
  logic [7:0] dest_q;
  cls_e       cls;
  logic       addr_ok, armed, pay_open;
  logic       ev_addr, ev_badcmd, ev_lock, ev_exec, ev_accept, ev_gated_run;
  logic [ERR_W-1:0] err_set;

  assign proto    = (mode_i == MODE_PROTO);
  assign data_tok = tok_valid_i & ~tok_eop_i;

  phi_hdr_track #(.HDR_LEN(HDR_LEN)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .proto_i    (proto),
    .tok_valid_i(tok_valid_i),
    .tok_eop_i  (tok_eop_i),
    .tok_data_i (tok_data_i),
    .hdr_stb_o  (hdr_stb),
    .hdr_done_o (hdr_done),
    .short_o    (hdr_short),
    .pay_stb_o  (pay_stb),
    .eop_o      (eop_seen),
    .dest_o     (dest_q),
    .ctrl_o     (hdr_ctrl_o),
    .tid_o      (hdr_tid_o)
  );

  assign cls     = classify(hdr_ctrl_o, NLINK);
  assign addr_ok = (dest_q == chan_addr_i);

  assign ev_addr      = hdr_done & ~addr_ok;
  assign ev_badcmd    = hdr_done & addr_ok & (cls == CL_BAD);
  assign ev_lock      = hdr_done & addr_ok & (cls == CL_GATED) & ~armed;
  assign ev_gated_run = hdr_done & addr_ok & (cls == CL_GATED) & armed;
  assign ev_exec      = hdr_done & addr_ok &
                        ((cls == CL_ARM) | (cls == CL_PLAIN) | ((cls == CL_GATED) & armed));
  assign ev_accept    = hdr_done & addr_ok & (cls == CL_DATA);

  phi_cmd_exec #(.NLINK(NLINK), .NSIG(NSIG)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (ev_exec),
    .ctl_i      (hdr_ctrl_o),
    .armed_o    (armed),
    .cpu_rst_n_o(cpu_rst_n_o),
    .sig_n_o    (sig_n_o),
    .link_rst_o (link_rst_o)
  );

  always_comb begin
    err_set            = '0;
    err_set[ERR_ADDR]  = ev_addr;
    err_set[ERR_CMD]   = ev_badcmd;
    err_set[ERR_LOCK]  = ev_lock;
    err_set[ERR_SHORT] = hdr_short;
  end

  phi_err_bank #(.W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (err_set),
    .clr_i  (err_clr_i),
    .en_i   (irq_en_i),
    .flags_o(err_flags_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_open    <= 1'b0;
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
      ack_valid_o <= 1'b0;
      ack_data_o  <= '0;
    end else begin
      if (!proto || eop_seen) pay_open <= 1'b0;
      else if (hdr_done)      pay_open <= ev_accept;
      fwd_valid_o <= (~proto & data_tok) | (pay_stb & pay_open);
      fwd_data_o  <= tok_data_i;
      ack_valid_o <= hdr_stb & auto_ack_i;
      ack_data_o  <= tok_data_i;
    end
  end
endmodule

// File: rtl/pkt_hdr_interp_chk.sv
module pkt_hdr_interp_chk #(
  parameter int NLINK = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             tok_valid_i,
  input logic             tok_eop_i,
  input logic [7:0]       tok_data_i,
  input logic             fwd_valid_o,
  input logic [7:0]       fwd_data_o,
  input logic             hdr_stb,
  input logic             ev_lock,
  input logic             ev_addr,
  input logic             ev_gated_run,
  input logic             armed,
  input logic             cpu_rst_n_o,
  input logic [NLINK-1:0] link_rst_o,
  input logic [3:0]       err_clr_i,
  input logic [3:0]       err_flags_o
);
  p_bypass_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid_i && !tok_eop_i && mode_i != 2'd2)
      |=> (fwd_valid_o && fwd_data_o == $past(tok_data_i)));

  p_eop_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid_i && tok_eop_i) |=> !fwd_valid_o);

  p_hdr_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |=> !fwd_valid_o);

  p_addr_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |=> err_flags_o[0]);

  p_lock_noeffect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> ($stable(cpu_rst_n_o) && link_rst_o == '0 && err_flags_o[2]));

  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gated_run |=> !armed);

  p_link_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rst_o != '0) |=> (link_rst_o == '0));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(err_flags_o) & ~$past(err_clr_i)) & ~err_flags_o) == 4'b0));
endmodule

bind pkt_hdr_interp pkt_hdr_interp_chk #(.NLINK(NLINK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .tok_valid_i (tok_valid_i),
  .tok_eop_i   (tok_eop_i),
  .tok_data_i  (tok_data_i),
  .fwd_valid_o (fwd_valid_o),
  .fwd_data_o  (fwd_data_o),
  .hdr_stb     (hdr_stb),
  .ev_lock     (ev_lock),
  .ev_addr     (ev_addr),
  .ev_gated_run(ev_gated_run),
  .armed       (armed),
  .cpu_rst_n_o (cpu_rst_n_o),
  .link_rst_o  (link_rst_o),
  .err_clr_i   (err_clr_i),
  .err_flags_o (err_flags_o)
);

// File: tb/tb_pkt_hdr_interp.sv
module tb_pkt_hdr_interp;
  localparam int NLINK = 3;
  localparam int NSIG  = 4;
  localparam logic [7:0] ME = 8'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] chan_addr_i = ME;
  logic auto_ack_i = 1'b0;
  logic tok_valid_i = 1'b0, tok_eop_i = 1'b0;
  logic [7:0] tok_data_i = '0;
  logic fwd_valid_o, ack_valid_o, cpu_rst_n_o, irq_o;
  logic [7:0] fwd_data_o, ack_data_o, hdr_ctrl_o, hdr_tid_o;
  logic [NSIG-1:0] sig_n_o;
  logic [NLINK-1:0] link_rst_o;
  logic [3:0] err_clr_i = '0, irq_en_i = '0, err_flags_o;

  int checks = 0, fails = 0;
  int fwd_cnt = 0, ack_cnt = 0;
  logic [7:0] last_fwd = '0;
  logic [7:0] ack_log [4];
  logic [NLINK-1:0] link_seen = '0;

  always #10 clk = ~clk;

  pkt_hdr_interp #(.NLINK(NLINK), .NSIG(NSIG), .HDR_LEN(4)) dut (.*);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tok(input logic eop, input logic [7:0] d);
    tok_valid_i = 1'b1; tok_eop_i = eop; tok_data_i = d;
    @(negedge clk);
    if (fwd_valid_o) begin fwd_cnt++; last_fwd = fwd_data_o; end
    if (ack_valid_o) begin
      if (ack_cnt < 4) ack_log[ack_cnt] = ack_data_o;
      ack_cnt++;
    end
    link_seen = link_seen | link_rst_o;
    tok_valid_i = 1'b0; tok_eop_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic pkt(input logic [7:0] dest, input logic [7:0] ctl, input logic [7:0] tid);
    tok(1'b1, 8'h00);
    tok(1'b0, dest);
    tok(1'b0, ctl);
    tok(1'b0, tid);
    tok(1'b0, 8'hEE);
  endtask

  task automatic clr_err();
    err_clr_i = '1; @(negedge clk); err_clr_i = '0;
  endtask

  task automatic t_reset();
    check(cpu_rst_n_o == 1'b1, "R6 reset cpu", cpu_rst_n_o, 1);
    check(sig_n_o == 4'hF, "R7 reset sig", sig_n_o, 4'hF);
    check(err_flags_o == 0 && irq_o == 0 && link_rst_o == 0, "R11 reset err", err_flags_o, 0);
    check(hdr_ctrl_o == 0 && hdr_tid_o == 0, "R9 reset hdr", hdr_tid_o, 0);
    check(fwd_valid_o == 0 && ack_valid_o == 0, "R1 reset fwd", fwd_valid_o, 0);
  endtask

  task automatic t_bypass();
    mode_i = 2'd0; fwd_cnt = 0;
    tok(1'b0, 8'hA5);
    check(fwd_cnt == 1 && last_fwd == 8'hA5, "R1 transparent data", last_fwd, 8'hA5);
    tok(1'b1, 8'h00);
    check(fwd_cnt == 1, "R1 eop not forwarded", fwd_cnt, 1);
    mode_i = 2'd1;
    pkt(ME, 8'h20, 8'h01);
    check(fwd_cnt == 5 && last_fwd == 8'hEE, "R1 routing forwards all", fwd_cnt, 5);
    check(cpu_rst_n_o == 1'b1 && err_flags_o == 0, "R1 no interpretation", err_flags_o, 0);
  endtask

  task automatic t_accept();
    mode_i = 2'd2; fwd_cnt = 0;
    pkt(ME, 8'h00, 8'h5C);
    check(fwd_cnt == 0, "R2 header hidden", fwd_cnt, 0);
    tok(1'b0, 8'h11); tok(1'b0, 8'h22); tok(1'b0, 8'h33);
    check(fwd_cnt == 3 && last_fwd == 8'h33, "R3 payload forwarded", last_fwd, 8'h33);
    check(hdr_ctrl_o == 8'h00 && hdr_tid_o == 8'h5C, "R9 header latched", hdr_tid_o, 8'h5C);
  endtask

  task automatic t_mismatch();
    fwd_cnt = 0;
    pkt(8'h17, 8'h00, 8'h01);
    tok(1'b0, 8'h44);
    check(fwd_cnt == 0, "R3 foreign payload dropped", fwd_cnt, 0);
    check(err_flags_o == 4'b0001, "R4 address error", err_flags_o, 1);
    clr_err();
    pkt(8'h33, 8'hF0, 8'h01);
    check(err_flags_o == 4'b0001, "R4 address before command", err_flags_o, 1);
    clr_err();
  endtask

  task automatic t_arm();
    fwd_cnt = 0;
    pkt(ME, 8'h20, 8'h00);
    check(cpu_rst_n_o == 1'b1 && err_flags_o == 4'b0100, "R5 disarmed hold", err_flags_o, 4);
    clr_err();
    pkt(ME, 8'h10, 8'h00);
    pkt(ME, 8'h20, 8'h00);
    check(cpu_rst_n_o == 1'b0 && err_flags_o == 0, "R6 armed cpu hold", cpu_rst_n_o, 0);
    link_seen = '0;
    pkt(ME, 8'h70, 8'h00);
    check(link_seen == 0 && err_flags_o == 4'b0100, "R5 one-shot disarm", err_flags_o, 4);
    clr_err();
    pkt(ME, 8'h30, 8'h00);
    tok(1'b0, 8'h99);
    check(cpu_rst_n_o == 1'b1 && err_flags_o == 0, "R6 cpu free ungated", cpu_rst_n_o, 1);
    check(fwd_cnt == 0, "R3 command payload dropped", fwd_cnt, 0);
  endtask

  task automatic t_sig();
    pkt(ME, 8'h45, 8'h00);
    check(sig_n_o == 4'b1010, "R7 sig assert", sig_n_o, 4'b1010);
    pkt(ME, 8'h51, 8'h00);
    check(sig_n_o == 4'b1011 && err_flags_o == 0, "R7 sig release", sig_n_o, 4'b1011);
  endtask

  task automatic t_link();
    pkt(ME, 8'h10, 8'h00);
    link_seen = '0;
    pkt(ME, 8'h61, 8'h00);
    check(link_seen == 3'b010, "R8 single link pulse", link_seen, 3'b010);
    idle();
    check(link_rst_o == 0, "R8 pulse one cycle", link_rst_o, 0);
    pkt(ME, 8'h10, 8'h00);
    link_seen = '0;
    pkt(ME, 8'h70, 8'h00);
    check(link_seen == 3'b111, "R8 all links", link_seen, 3'b111);
    link_seen = '0;
    pkt(ME, 8'h63, 8'h00);
    check(link_seen == 0 && err_flags_o == 4'b0010, "R8 index out of range", err_flags_o, 2);
    clr_err();
    pkt(ME, 8'hF0, 8'h00);
    check(err_flags_o == 4'b0010, "R8 unknown opcode", err_flags_o, 2);
    clr_err();
  endtask

  task automatic t_short();
    fwd_cnt = 0;
    tok(1'b1, 8'h00); tok(1'b0, ME); tok(1'b0, 8'h00); tok(1'b1, 8'h00);
    check(err_flags_o == 4'b1000, "R10 short header", err_flags_o, 8);
    tok(1'b0, ME); tok(1'b0, 8'h00); tok(1'b0, 8'h77); tok(1'b0, 8'h00); tok(1'b0, 8'h55);
    check(fwd_cnt == 1 && last_fwd == 8'h55, "R10 restart parse", last_fwd, 8'h55);
    check(hdr_tid_o == 8'h77, "R9 new tid", hdr_tid_o, 8'h77);
    clr_err();
  endtask

  task automatic t_sticky();
    irq_en_i = 4'b0000;
    pkt(8'h17, 8'h00, 8'h00);
    pkt(ME, 8'hF0, 8'h00);
    check(err_flags_o == 4'b0011 && irq_o == 0, "R11 masked irq", err_flags_o, 3);
    irq_en_i = 4'b0010; #1;
    check(irq_o == 1'b1, "R11 irq enabled", irq_o, 1);
    @(negedge clk);
    err_clr_i = 4'b0001; @(negedge clk); err_clr_i = '0;
    idle(); idle();
    check(err_flags_o == 4'b0010 && irq_o == 1, "R11 partial clear", err_flags_o, 2);
    err_clr_i = 4'b0010; @(negedge clk); err_clr_i = '0;
    check(err_flags_o == 0 && irq_o == 0, "R11 full clear", err_flags_o, 0);
    err_clr_i = 4'b0001;
    pkt(8'h17, 8'h00, 8'h00);
    err_clr_i = '0;
    check(err_flags_o[0] == 1'b1, "R11 set wins", err_flags_o, 1);
    clr_err();
    irq_en_i = '0;
  endtask

  task automatic t_ack();
    auto_ack_i = 1'b1; ack_cnt = 0;
    tok(1'b1, 8'h00); tok(1'b0, ME); tok(1'b0, 8'h00); tok(1'b0, 8'h66); tok(1'b0, 8'h3C);
    tok(1'b0, 8'h12);
    check(ack_cnt == 4, "R12 four ack bytes", ack_cnt, 4);
    check(ack_log[0] == ME && ack_log[2] == 8'h66 && ack_log[3] == 8'h3C,
          "R12 ack content", ack_log[2], 8'h66);
    auto_ack_i = 1'b0; ack_cnt = 0;
    pkt(ME, 8'h00, 8'h01);
    check(ack_cnt == 0, "R12 ack off", ack_cnt, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_accept();
    t_mismatch();
    t_arm();
    t_sig();
    t_link();
    t_short();
    t_sticky();
    t_ack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule